// File: doc/BRIEF.md
# Virtualizable Counter and Compare Timer

This block is a per-core time unit. A 64-bit count starts at zero when reset is released and advances by one on every clock. From it the block derives a physical count and a guest-visible virtual count. The virtual count is the physical count less an offset register. Only an access flagged as privileged can change that offset, so a hypervisor can make a guest's count begin near zero.

Three comparator timers sit on these counts. Timer 0 is the guest physical timer, timer 1 is the guest virtual timer, and timer 2 is the physical timer kept for the hypervisor. Each timer can be armed in two ways: by writing an absolute deadline, or by writing a signed relative distance that is added to the current count of its own domain. Each timer drives its own level-sensitive interrupt line.

Software reaches every register through a flat address/data bus with write and read strobes. Read data is combinational and is zero when the read strobe is low.

Top module: `vctimer_unit`

## Requirements
- R1: The physical count (address 0, read-only) is zero during reset and increases by exactly one on every clock edge after reset is released.
- R2: The virtual count (address 1, read-only) always equals the physical count minus the offset register (address 2), modulo 2^64.
- R3: A write to address 2 updates the offset only when `bus_priv` is 1. A write with `bus_priv` at 0 leaves the offset and the virtual count unchanged.
- R4: Timer t owns addresses 4+4t (control), 5+4t (absolute deadline) and 6+4t (relative). Writing 5+4t stores the write data as the deadline.
- R5: Writing 6+4t loads the deadline with the timer's current domain count plus `bus_wdata[31:0]`, sign-extended to 64 bits.
- R6: Reading 6+4t returns the lower 32 bits of (deadline minus current domain count), sign-extended to 64 bits.
- R7: The control register holds bit 0 = enable and bit 1 = mask (both read/write, both 0 after reset). Bit 2 is a read-only status that is 1 exactly when the domain count is greater than or equal to the deadline (unsigned), whatever the enable and mask settings.
- R8: `irq_o[t]` equals enable AND NOT mask AND status. It drops as soon as the deadline is moved into the future, or the timer is disabled or masked.
- R9: Timer 0 and timer 2 compare against the physical count, and timer 1 compares against the virtual count. Each timer drives only its own bit of `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter and register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_rd | input | 1 | Read strobe; enables `bus_rdata` |
| bus_priv | input | 1 | Marks the current access as hypervisor-level |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data, combinational, zero when idle |
| irq_o | output | 3 | Per-timer interrupt lines: bit 0 physical, bit 1 virtual, bit 2 hypervisor |

## Verification
The assertions assume that `bus_wr` and `bus_rd` are never both high, and that every write strobe lasts exactly one clock with address and data held steady across that edge. The deadline-load checks compare against the count sampled at the write edge and depend on this. The bench changes bus signals only on the falling edge and drops the write strobe just after the rising edge. It keeps the offset small and the counts far from wrap-around, so unsigned comparisons in the bench and in the design agree.

// File: rtl/vct_pkg.sv
package vct_pkg;

   // fixed register words at the bottom of the map
   localparam int unsigned REG_PCNT = 0;
   localparam int unsigned REG_VCNT = 1;
   localparam int unsigned REG_OFS  = 2;

   // per-timer register window
   localparam int unsigned TMR_BASE   = 4;
   localparam int unsigned TMR_STRIDE = 4;
   localparam int unsigned SUB_CTRL   = 0;
   localparam int unsigned SUB_CVAL   = 1;
   localparam int unsigned SUB_TVAL   = 2;

   // control bit positions
   localparam int unsigned CB_EN  = 0;
   localparam int unsigned CB_MSK = 1;
   localparam int unsigned CB_ST  = 2;

   typedef enum logic [0:0] {
      DOM_PHYS = 1'b0,
      DOM_VIRT = 1'b1
   } dom_e;

   function automatic int unsigned tmr_word(int unsigned t, int unsigned sub);
      return TMR_BASE + t * TMR_STRIDE + sub;
   endfunction

endpackage

// File: rtl/vct_sys_counter.sv
module vct_sys_counter #(
   parameter int unsigned CNT_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ofs_wr,
   input  logic             ofs_priv,
   input  logic [CNT_W-1:0] wdata,
   output logic [CNT_W-1:0] phys_cnt,
   output logic [CNT_W-1:0] virt_cnt,
   output logic [CNT_W-1:0] ofs_q
);

   logic ofs_take;
   assign ofs_take = ofs_wr & ofs_priv;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phys_cnt <= '0;
         ofs_q    <= '0;
      end else begin
         phys_cnt <= phys_cnt + CNT_W'(1);
         if (ofs_take) begin
            ofs_q <= wdata;
         end
      end
   end

   assign virt_cnt = phys_cnt - ofs_q;

endmodule

// File: rtl/vct_addr_decode.sv
module vct_addr_decode
   import vct_pkg::*;
#(
   parameter int unsigned ADDR_W  = 4,
   parameter int unsigned NUM_TMR = 3
) (
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   output logic              ofs_wr,
   output logic [NUM_TMR-1:0] ctrl_wr,
   output logic [NUM_TMR-1:0] cval_wr,
   output logic [NUM_TMR-1:0] tval_wr
);

   assign ofs_wr = bus_wr && (bus_addr == ADDR_W'(REG_OFS));

   for (genvar t = 0; t < NUM_TMR; t++) begin : g_dec
      localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(tmr_word(t, SUB_CTRL));
      localparam logic [ADDR_W-1:0] A_CVAL = ADDR_W'(tmr_word(t, SUB_CVAL));
      localparam logic [ADDR_W-1:0] A_TVAL = ADDR_W'(tmr_word(t, SUB_TVAL));
      assign ctrl_wr[t] = bus_wr && (bus_addr == A_CTRL);
      assign cval_wr[t] = bus_wr && (bus_addr == A_CVAL);
      assign tval_wr[t] = bus_wr && (bus_addr == A_TVAL);
   end

endmodule

// File: rtl/vct_cmp_timer.sv
module vct_cmp_timer
   import vct_pkg::*;
#(
   parameter int unsigned CNT_W  = 64,
   parameter int unsigned TVAL_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] dom_cnt,
   input  logic             ctrl_wr,
   input  logic             cval_wr,
   input  logic             tval_wr,
   input  logic [CNT_W-1:0] wdata,
   output logic [CNT_W-1:0] ctrl_rd,
   output logic [CNT_W-1:0] cval_q,
   output logic [CNT_W-1:0] tval_rd,
   output logic             en_q,
   output logic             msk_q,
   output logic             irq
);

   localparam int unsigned EXT_W = CNT_W - TVAL_W;

   logic [CNT_W-1:0] rel_sx;
   logic [CNT_W-1:0] remain;
   logic             hit;

   assign rel_sx = {{EXT_W{wdata[TVAL_W-1]}}, wdata[TVAL_W-1:0]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cval_q <= '0;
         en_q   <= 1'b0;
         msk_q  <= 1'b0;
      end else begin
         if (ctrl_wr) begin
            en_q  <= wdata[CB_EN];
            msk_q <= wdata[CB_MSK];
         end
         if (cval_wr) begin
            cval_q <= wdata;
         end else if (tval_wr) begin
            cval_q <= dom_cnt + rel_sx;
         end
      end
   end

   assign hit    = (dom_cnt >= cval_q);
   assign remain = cval_q - dom_cnt;
   assign tval_rd = {{EXT_W{remain[TVAL_W-1]}}, remain[TVAL_W-1:0]};

   always_comb begin
      ctrl_rd         = '0;
      ctrl_rd[CB_EN]  = en_q;
      ctrl_rd[CB_MSK] = msk_q;
      ctrl_rd[CB_ST]  = hit;
   end

   assign irq = en_q & ~msk_q & hit;

endmodule

// File: rtl/vctimer_unit.sv
module vctimer_unit
   import vct_pkg::*;
#(
   parameter int unsigned CNT_W   = 64,
   parameter int unsigned TVAL_W  = 32,
   parameter int unsigned NUM_TMR = 3,
   parameter int unsigned ADDR_W  = 4,
   parameter logic [NUM_TMR-1:0] VIRT_MAP = 3'b010
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_wr,
   input  logic               bus_rd,
   input  logic               bus_priv,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [CNT_W-1:0]   bus_wdata,
   output logic [CNT_W-1:0]   bus_rdata,
   output logic [NUM_TMR-1:0] irq_o
);

   localparam int unsigned MAP_WORDS = TMR_BASE + NUM_TMR * TMR_STRIDE;

   if (TVAL_W >= CNT_W) begin : g_bad_tval
      $error("TVAL_W must be narrower than CNT_W");
   end
   if ((1 << ADDR_W) < MAP_WORDS) begin : g_bad_addr
      $error("ADDR_W too narrow for the register map");
   end
   if (NUM_TMR < 1) begin : g_bad_num
      $error("NUM_TMR must be at least one");
   end

   logic [CNT_W-1:0] phys_cnt;
   logic [CNT_W-1:0] virt_cnt;
   logic [CNT_W-1:0] ofs_q;
   logic             ofs_wr;

   logic [NUM_TMR-1:0]            ctrl_wr;
   logic [NUM_TMR-1:0]            cval_wr;
   logic [NUM_TMR-1:0]            tval_wr;
   logic [NUM_TMR-1:0]            en_q;
   logic [NUM_TMR-1:0]            msk_q;
   logic [NUM_TMR-1:0][CNT_W-1:0] dom_cnt;
   logic [NUM_TMR-1:0][CNT_W-1:0] cmp_q;
   logic [NUM_TMR-1:0][CNT_W-1:0] ctrl_rd;
   logic [NUM_TMR-1:0][CNT_W-1:0] tval_rd;

   vct_sys_counter #(.CNT_W(CNT_W)) cnt_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .ofs_wr   (ofs_wr),
      .ofs_priv (bus_priv),
      .wdata    (bus_wdata),
      .phys_cnt (phys_cnt),
      .virt_cnt (virt_cnt),
      .ofs_q    (ofs_q)
   );

   vct_addr_decode #(.ADDR_W(ADDR_W), .NUM_TMR(NUM_TMR)) dec_i (
      .bus_wr   (bus_wr),
      .bus_addr (bus_addr),
      .ofs_wr   (ofs_wr),
      .ctrl_wr  (ctrl_wr),
      .cval_wr  (cval_wr),
      .tval_wr  (tval_wr)
   );

   for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
      if (VIRT_MAP[t] == DOM_VIRT) begin : g_virt
         assign dom_cnt[t] = virt_cnt;
      end else begin : g_phys
         assign dom_cnt[t] = phys_cnt;
      end

      vct_cmp_timer #(.CNT_W(CNT_W), .TVAL_W(TVAL_W)) tmr_i (
         .clk     (clk),
         .rst_n   (rst_n),
         .dom_cnt (dom_cnt[t]),
         .ctrl_wr (ctrl_wr[t]),
         .cval_wr (cval_wr[t]),
         .tval_wr (tval_wr[t]),
         .wdata   (bus_wdata),
         .ctrl_rd (ctrl_rd[t]),
         .cval_q  (cmp_q[t]),
         .tval_rd (tval_rd[t]),
         .en_q    (en_q[t]),
         .msk_q   (msk_q[t]),
         .irq     (irq_o[t])
      );
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         if (bus_addr == ADDR_W'(REG_PCNT)) bus_rdata = phys_cnt;
         if (bus_addr == ADDR_W'(REG_VCNT)) bus_rdata = virt_cnt;
         if (bus_addr == ADDR_W'(REG_OFS))  bus_rdata = ofs_q;
         for (int t = 0; t < NUM_TMR; t++) begin
            if (bus_addr == ADDR_W'(tmr_word(t, SUB_CTRL))) bus_rdata = ctrl_rd[t];
            if (bus_addr == ADDR_W'(tmr_word(t, SUB_CVAL))) bus_rdata = cmp_q[t];
            if (bus_addr == ADDR_W'(tmr_word(t, SUB_TVAL))) bus_rdata = tval_rd[t];
         end
      end
   end

endmodule

// File: rtl/vct_checker.sv
module vct_checker
   import vct_pkg::*;
#(
   parameter int unsigned CNT_W   = 64,
   parameter int unsigned TVAL_W  = 32,
   parameter int unsigned NUM_TMR = 3,
   parameter int unsigned ADDR_W  = 4
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      bus_wr,
   input logic                      bus_priv,
   input logic [ADDR_W-1:0]         bus_addr,
   input logic [CNT_W-1:0]          bus_wdata,
   input logic [NUM_TMR-1:0]        irq_o,
   input logic [CNT_W-1:0]          phys_cnt,
   input logic [CNT_W-1:0]          ofs_q,
   input logic [NUM_TMR-1:0]        en_q,
   input logic [NUM_TMR-1:0]        msk_q,
   input logic [NUM_TMR-1:0][CNT_W-1:0] dom_cnt,
   input logic [NUM_TMR-1:0][CNT_W-1:0] cmp_q
);

   logic             past_ok;
   logic [CNT_W-1:0] wd_sx;
   logic             ofs_req;

   always_ff @(posedge clk) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   assign wd_sx   = {{(CNT_W-TVAL_W){bus_wdata[TVAL_W-1]}}, bus_wdata[TVAL_W-1:0]};
   assign ofs_req = bus_wr && bus_priv && (bus_addr == ADDR_W'(REG_OFS));

   // R1
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> phys_cnt == $past(phys_cnt) + CNT_W'(1));

   // R3
   ofs_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !$past(ofs_req)) |-> ofs_q == $past(ofs_q));

   for (genvar t = 0; t < NUM_TMR; t++) begin : g_chk
      localparam logic [ADDR_W-1:0] A_CVAL = ADDR_W'(tmr_word(t, SUB_CVAL));
      localparam logic [ADDR_W-1:0] A_TVAL = ADDR_W'(tmr_word(t, SUB_TVAL));

      // R8
      irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
         irq_o[t] |-> (en_q[t] && !msk_q[t]));

      // R8
      irq_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
         irq_o[t] |-> (dom_cnt[t] >= cmp_q[t]));

      // R4
      abs_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (past_ok && $past(bus_wr && bus_addr == A_CVAL)) |-> cmp_q[t] == $past(bus_wdata));

      // R5
      rel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (past_ok && $past(bus_wr && bus_addr == A_TVAL))
            |-> cmp_q[t] == $past(dom_cnt[t]) + $past(wd_sx));
   end

endmodule

bind vctimer_unit vct_checker #(
   .CNT_W(CNT_W), .TVAL_W(TVAL_W), .NUM_TMR(NUM_TMR), .ADDR_W(ADDR_W)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_priv  (bus_priv),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .irq_o     (irq_o),
   .phys_cnt  (phys_cnt),
   .ofs_q     (ofs_q),
   .en_q      (en_q),
   .msk_q     (msk_q),
   .dom_cnt   (dom_cnt),
   .cmp_q     (cmp_q)
);

// File: tb/vctimer_unit_tb_top.sv
module vctimer_unit_tb_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        bus_wr, bus_rd, bus_priv;
   logic [3:0]  bus_addr;
   logic [63:0] bus_wdata, bus_rdata;
   logic [2:0]  irq_o;

   int errs   = 0;
   int checks = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   vctimer_unit dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_priv(bus_priv), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq_o(irq_o)
   );

   // vector: [15:14] timer, [13] relative, [12] enable, [11] mask, [7:0] signed distance
   localparam logic [15:0] VEC [8] = '{
      {2'd0, 1'b0, 1'b1, 1'b0, 3'b0, 8'sd5},
      {2'd0, 1'b1, 1'b1, 1'b0, 3'b0, 8'sd4},
      {2'd1, 1'b0, 1'b1, 1'b0, 3'b0, 8'sd3},
      {2'd1, 1'b1, 1'b1, 1'b1, 3'b0, 8'sd6},
      {2'd2, 1'b0, 1'b1, 1'b0, 3'b0, 8'sd2},
      {2'd2, 1'b1, 1'b1, 1'b0, 3'b0, -8'sd3},
      {2'd0, 1'b1, 1'b0, 1'b0, 3'b0, 8'sd1},
      {2'd2, 1'b1, 1'b1, 1'b0, 3'b0, 8'sd0}
   };

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [3:0] a, output logic [63:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      bus_rd = 1'b0;
   endtask

   task automatic wr(input logic [3:0] a, input logic [63:0] d, input logic p);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_priv = p; bus_wr = 1'b1;
      @(posedge clk);
      #1 bus_wr = 1'b0; bus_priv = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   endtask

   initial begin
      #(20 * 200000);
      errs++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      logic [63:0] a, b, p, v;
      rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_priv = 1'b0;
      bus_addr = '0; bus_wdata = '0;
      repeat (3) @(posedge clk);

      // reset state: R1 count zero, R7 control cleared, R8 no interrupts
      rd(4'd0, a);  chk("R1 count in reset", a, 64'd0);
      rd(4'd4, a);  chk("R7 ctrl reset en/msk", {62'd0, a[1:0]}, 64'd0);
      chk("R8 irq in reset", {61'd0, irq_o}, 64'd0);
      @(negedge clk); rst_n = 1'b1;

      // R1 step
      rd(4'd0, a); rd(4'd0, b);
      chk("R1 count step", b, a + 64'd1);

      // R2, R3 offset
      wr(4'd2, 64'd5, 1'b1);
      rd(4'd2, a); chk("R3 privileged offset write", a, 64'd5);
      rd(4'd0, p); rd(4'd1, v);
      chk("R2 virtual count", v, p + 64'd1 - 64'd5);
      wr(4'd2, 64'h1234, 1'b0);
      rd(4'd2, a); chk("R3 unprivileged offset write ignored", a, 64'd5);
      rd(4'd0, p); rd(4'd1, v);
      chk("R3 virtual count unchanged", v, p + 64'd1 - 64'd5);

      // table walk: R4 R5 R6 R7 R8 R9
      for (int i = 0; i < 8; i++) begin
         logic [15:0] e;
         int t, d, lim;
         logic rel, en, msk, st;
         logic [63:0] r, q;
         e = VEC[i];
         t = int'(e[15:14]); rel = e[13]; en = e[12]; msk = e[11];
         d = int'($signed(e[7:0]));
         wr(4'(4 + 4*t), {62'd0, msk, en}, 1'b0);
         @(negedge clk);
         bus_addr = (t == 1) ? 4'd1 : 4'd0; bus_rd = 1'b1;
         #1 q = bus_rdata; bus_rd = 1'b0;
         bus_addr = 4'(4 + 4*t + (rel ? 2 : 1));
         bus_wdata = rel ? 64'(longint'(d)) : q + 64'(longint'(d));
         bus_wr = 1'b1;
         @(posedge clk);
         #1 bus_wr = 1'b0;
         // R6 remaining distance one count after arming
         rd(4'(4 + 4*t + 2), r);
         chk($sformatf("R6 remaining vec%0d", i), r, 64'(longint'(d - 1)));
         lim = (d <= 2) ? 3 : d + 1;
         for (int j = 2; j <= lim; j++) begin
            rd(4'(4 + 4*t), r);
            st = (j >= d);
            chk($sformatf("R7 status vec%0d j%0d", i, j), {61'd0, r[2:0]}, {61'd0, st, msk, en});
            chk($sformatf("R8 R9 irq vec%0d j%0d", i, j), {63'd0, irq_o[t]}, {63'd0, en & ~msk & st});
         end
         wr(4'(4 + 4*t), 64'd0, 1'b0);
      end

      // R8 level deassert on future deadline, mask, disable
      wr(4'd4, 64'd1, 1'b0);
      wr(4'd5, 64'd0, 1'b0);
      rd(4'd4, a); chk("R8 irq raised", {63'd0, irq_o[0]}, 64'd1);
      wr(4'd5, '1, 1'b0);
      rd(4'd4, a); chk("R8 irq drops on future deadline", {63'd0, irq_o[0]}, 64'd0);
      chk("R7 status clear", {63'd0, a[2]}, 64'd0);
      wr(4'd5, 64'd0, 1'b0);
      wr(4'd4, 64'd3, 1'b0);
      rd(4'd4, a); chk("R8 irq drops on mask", {63'd0, irq_o[0]}, 64'd0);
      chk("R7 status seen while masked", {63'd0, a[2]}, 64'd1);
      wr(4'd4, 64'd0, 1'b0);
      rd(4'd4, a); chk("R8 irq drops on disable", {63'd0, irq_o[0]}, 64'd0);
      chk("R9 other lines quiet", {62'd0, irq_o[2:1]}, 64'd0);

      finish_run();
   end

endmodule